// File: doc/BRIEF.md
# Direct-Mapped Cache Hit/Miss Profiler

This block models only the tag side of a direct-mapped cache and uses it to profile the hit rate of an address stream. Each cycle in which the access strobe is high, the incoming word address is split into a line index and a tag. The block then classifies the access as a hit or a miss and raises one of two response pulses on the following cycle. It keeps three saturating statistics counters alongside. No data is stored and nothing is fetched: a miss simply installs the new tag in its line.

The line count and the number of words per line are parameters, both powers of two. A synchronous clear empties every line and zeroes all counters in one cycle. This lets software-free profiling windows be opened at any point in a trace.

Top module: `dmcp_hit_profiler`

## Requirements
- R1: The block number is the word address shifted right by log2(WORDS); the line index is the low log2(LINES) bits of the block number, and the tag is its remaining upper bits.
- R2: An access hits only if its line is valid and the stored tag equals the access tag; otherwise it misses.
- R3: One cycle after an accepted access exactly one of `hit_o`/`miss_o` is high for one cycle; in every other cycle both are low, and they are never high together.
- R4: A miss overwrites its line with the new tag (evicting any occupant); a hit leaves the line unchanged.
- R5: After reset every line is empty and all counters read zero, so the first access to any line misses.
- R6: Each accepted access adds one to `total_o` and one to exactly one of `hits_o` or `misses_o`; the new counts are visible in the same cycle as the response pulse.
- R7: Each counter stops at its all-ones value instead of wrapping.
- R8: `clr_i` empties all lines and zeroes all counters in one cycle; an access presented in the same cycle is dropped (no pulse, not counted, not installed).
- R9: With 16 lines of one word, the stream 1,4,8,5,20,17,19,56,9,11,4,43,5,6,9,17 yields 16 accesses, 3 hits and 13 misses.
- R10: With 4 lines of 4 words, the same stream yields 6 hits and 10 misses, the hits being 5, 19, 11, the second 5, 6 and the second 17.
- R11: Back-to-back accesses are classified in order; an access sees the tag installed by the access in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of lines and counters |
| acc_vld_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Word address of the access |
| hit_o | output | 1 | Registered hit pulse |
| miss_o | output | 1 | Registered miss pulse |
| total_o | output | CNT_W | Accepted access count |
| hits_o | output | CNT_W | Hit count |
| misses_o | output | CNT_W | Miss count |

## Verification
The lookup, the line update and the counter increments all happen at the clock edge that samples the strobe. The response pulse and the new counter values are therefore both due exactly one cycle after the stimulus, and a clear shows zeroed counters one cycle after it is raised. The bench drives each stimulus on a falling edge and checks every output on the next falling edge, with one rising edge in between. Consecutive accesses are issued on consecutive cycles, so the same timing also checks that each access sees the update made by the one before.

// File: rtl/dmcp_pkg.sv
package dmcp_pkg;

  // Index of each statistics counter inside the counter bank.
  typedef enum int unsigned {
    CNT_TOTAL = 0,
    CNT_HIT   = 1,
    CNT_MISS  = 2
  } dmcp_cnt_e;

  localparam int unsigned NUM_CNT = 3;

  // Response registered one cycle after an access.
  typedef struct packed {
    logic hit;
    logic miss;
  } dmcp_resp_t;

endpackage

// File: rtl/dmcp_addr_split.sv
module dmcp_addr_split #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORDS  = 1,
  localparam int unsigned OFF_W = $clog2(WORDS),
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);

  // Word-within-line bits do not take part in the lookup.
  generate
    if (OFF_W > 0) begin : g_off
      logic [OFF_W-1:0] unused_off;
      assign unused_off = addr_i[OFF_W-1:0];
    end
  endgenerate

  assign idx_o = addr_i[OFF_W +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/dmcp_tag_store.sv
module dmcp_tag_store #(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAG_W = 12,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wr_en_i,
  output logic             match_o
);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // Tag array: no reset, single write port, so it maps to distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en_i) tag_mem[idx_i] <= tag_i;
  end

  // Valid bits live in flops so that a clear empties every line at once.
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= 1'b1;
    end
  end

  assign match_o = valid_q[idx_i] && (tag_mem[idx_i] == tag_i);

endmodule

// File: rtl/dmcp_sat_cnt.sv
module dmcp_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dmcp_hit_profiler.sv
module dmcp_hit_profiler
  import dmcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LINES  = 16,
  parameter int unsigned WORDS  = 1,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              acc_vld_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [CNT_W-1:0]  total_o,
  output logic [CNT_W-1:0]  hits_o,
  output logic [CNT_W-1:0]  misses_o
);

  localparam int unsigned OFF_W = $clog2(WORDS);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             match;
  logic             accept;
  logic             install;
  dmcp_resp_t       resp_q;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  dmcp_addr_split #(
    .ADDR_W (ADDR_W),
    .LINES  (LINES),
    .WORDS  (WORDS)
  ) u_split (
    .addr_i (acc_addr_i),
    .idx_o  (idx),
    .tag_o  (tag)
  );

  // Clear wins over a coincident access.
  assign accept  = acc_vld_i && !clr_i;
  assign install = accept && !match;

  dmcp_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .idx_i   (idx),
    .tag_i   (tag),
    .wr_en_i (install),
    .match_o (match)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      resp_q <= '0;
    end else begin
      resp_q.hit  <= accept && match;
      resp_q.miss <= accept && !match;
    end
  end

  assign inc[CNT_TOTAL] = accept;
  assign inc[CNT_HIT]   = accept && match;
  assign inc[CNT_MISS]  = accept && !match;

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      dmcp_sat_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .inc_i (inc[g]),
        .cnt_o (cnt[g])
      );
    end
  endgenerate

  assign hit_o    = resp_q.hit;
  assign miss_o   = resp_q.miss;
  assign total_o  = cnt[CNT_TOTAL];
  assign hits_o   = cnt[CNT_HIT];
  assign misses_o = cnt[CNT_MISS];

endmodule

// File: rtl/dmcp_checker.sv
module dmcp_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             acc_vld_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic [CNT_W-1:0] total_o,
  input logic [CNT_W-1:0] hits_o,
  input logic [CNT_W-1:0] misses_o
);

  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  // R3: hit and miss are never high together
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_o, miss_o}));

  // R3: an accepted access produces a response one cycle later
  a_r3_response: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && !clr_i) |=> (hit_o || miss_o));

  // R3: no response without an accepted access
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    (!acc_vld_i || clr_i) |=> (!hit_o && !miss_o));

  // R8: clear zeroes every counter in one cycle
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (total_o == '0 && hits_o == '0 && misses_o == '0));

  // R7: the access count never decreases outside a clear
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (total_o >= $past(total_o)));

  // R6: an accepted access advances the total unless it is saturated
  a_r6_total_step: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && !clr_i) |=>
      ((total_o == $past(total_o) + ONE) || ($past(total_o) == MAXV)));

endmodule

bind dmcp_hit_profiler dmcp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_i     (clr_i),
  .acc_vld_i (acc_vld_i),
  .hit_o     (hit_o),
  .miss_o    (miss_o),
  .total_o   (total_o),
  .hits_o    (hits_o),
  .misses_o  (misses_o)
);

// File: tb/dmcp_hit_profiler_tb_top.sv
module dmcp_hit_profiler_tb_top;

  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic vld = 1'b0;
  logic [AW-1:0] addr = '0;

  always #10 clk = ~clk;

  // Config 0: 16 lines x 1 word, 16-bit counters
  logic a_hit, a_miss;
  logic [15:0] a_tot, a_hits, a_mis;
  // Config 1: 4 lines x 4 words, 4-bit counters
  logic b_hit, b_miss;
  logic [3:0] b_tot, b_hits, b_mis;

  dmcp_hit_profiler #(.ADDR_W(AW), .LINES(16), .WORDS(1), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .clr_i(clr), .acc_vld_i(vld), .acc_addr_i(addr),
    .hit_o(a_hit), .miss_o(a_miss), .total_o(a_tot), .hits_o(a_hits), .misses_o(a_mis));

  dmcp_hit_profiler #(.ADDR_W(AW), .LINES(4), .WORDS(4), .CNT_W(4)) dut_b (
    .clk(clk), .rst(rst), .clr_i(clr), .acc_vld_i(vld), .acc_addr_i(addr),
    .hit_o(b_hit), .miss_o(b_miss), .total_o(b_tot), .hits_o(b_hits), .misses_o(b_mis));

  // Reference model, one slot per configuration
  bit mv [2][16];
  int mt [2][16];
  int etot [2], ehit [2], emis [2];
  bit eh [2], em [2];
  int lines_c [2] = '{16, 4};
  int words_c [2] = '{1, 4};
  int cmax_c  [2] = '{65535, 15};

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic void m_clear();
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 16; i++) begin
        mv[c][i] = 0;
        mt[c][i] = 0;
      end
      etot[c] = 0; ehit[c] = 0; emis[c] = 0;
      eh[c] = 0; em[c] = 0;
    end
  endfunction

  function automatic int sat_inc(int v, int c);
    return (v >= cmax_c[c]) ? v : v + 1;
  endfunction

  function automatic bit m_step(int c, int a);
    int blk, idx, tg;
    bit h;
    blk = a / words_c[c];
    idx = blk % lines_c[c];
    tg  = blk / lines_c[c];
    h = mv[c][idx] && (mt[c][idx] == tg);
    if (!h) begin
      mv[c][idx] = 1;
      mt[c][idx] = tg;
    end
    etot[c] = sat_inc(etot[c], c);
    if (h) ehit[c] = sat_inc(ehit[c], c);
    else   emis[c] = sat_inc(emis[c], c);
    return h;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "A hit",    int'(a_hit),  int'(eh[0]));
    chk(req, "A miss",   int'(a_miss), int'(em[0]));
    chk(req, "A total",  int'(a_tot),  etot[0]);
    chk(req, "A hits",   int'(a_hits), ehit[0]);
    chk(req, "A misses", int'(a_mis),  emis[0]);
    chk(req, "B hit",    int'(b_hit),  int'(eh[1]));
    chk(req, "B miss",   int'(b_miss), int'(em[1]));
    chk(req, "B total",  int'(b_tot),  etot[1]);
    chk(req, "B hits",   int'(b_hits), ehit[1]);
    chk(req, "B misses", int'(b_mis),  emis[1]);
  endtask

  // Called at a falling edge; outputs are checked at the next falling edge.
  task automatic drive(bit v, bit c, int a, string req);
    vld  = v;
    clr  = c;
    addr = AW'(a);
    if (c) begin
      m_clear();
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (v) begin
          eh[k] = m_step(k, a);
          em[k] = !eh[k];
        end else begin
          eh[k] = 0;
          em[k] = 0;
        end
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  int seq [16] = '{1, 4, 8, 5, 20, 17, 19, 56, 9, 11, 4, 43, 5, 6, 9, 17};
  bit b_exp_hit [16] = '{0, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0, 0, 1, 1, 0, 1};

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    m_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset state
    check_all("R5");

    // R9 / R10 / R11: the reference stream, back to back
    for (int i = 0; i < 16; i++) begin
      drive(1, 0, seq[i], "R11");
      chk("R10", "B listed hit", int'(b_hit), int'(b_exp_hit[i]));
    end
    drive(0, 0, 0, "R3");
    chk("R9", "A total", int'(a_tot), 16);
    chk("R9", "A hits", int'(a_hits), 3);
    chk("R9", "A misses", int'(a_mis), 13);
    chk("R10", "B hits", int'(b_hits), 6);
    chk("R10", "B misses", int'(b_mis), 10);
    // R7: 16 accesses saturate the 4-bit total
    chk("R7", "B total saturated", int'(b_tot), 15);

    // R8: clear, then clear with a coincident access that must be dropped
    drive(0, 1, 0, "R8");
    drive(1, 1, 33, "R8");
    drive(1, 0, 33, "R8");
    chk("R8", "A dropped access not installed", int'(a_miss), 1);

    // R4 / R1: eviction by an aliasing address, then restore
    drive(0, 1, 0, "R8");
    drive(1, 0, 4, "R4");
    drive(1, 0, 20, "R4");
    drive(1, 0, 4, "R4");
    chk("R4", "A 4 after eviction", int'(a_miss), 1);
    drive(1, 0, 4, "R4");
    chk("R4", "A 4 unchanged hit", int'(a_hit), 1);
    // R1: same block in config B, different word
    drive(1, 0, 7, "R1");
    chk("R1", "B same block hit", int'(b_hit), 1);
    // R2: first touch of an empty line misses
    drive(1, 0, 2, "R2");
    chk("R2", "A empty line miss", int'(a_miss), 1);
    drive(0, 0, 0, "R3");

    // Random phase: R2 R3 R6 R7 R8
    for (int i = 0; i < 600; i++) begin
      bit v, c;
      v = ($urandom % 4) != 0;
      c = ($urandom % 60) == 0;
      drive(v, c, int'($urandom % 64), "R6");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule